// File: doc/BRIEF.md
# Power-On Sequencer and Register-Reset Interrupt Controller

This block is the digital control core of a power-management device. It takes the device from reset to an idle STANDBY state and reports every register reset to the host microcontroller. An external active-high reset-release pin and an undervoltage flag for the analog supply are resynchronised. While either one holds the device off, all control logic is parked. When both allow operation, a startup window runs: the default register values load and the register bus stays closed. The length of the window comes from a clock-frequency parameter and a wait time given in microseconds, 1.2 ms by default.

When the window ends, the block enters STANDBY and opens a small register port. The port has a self-clearing software-reset control, a reset-cause status bit that is cleared by writing one, a mask for that bit, and one general configuration register. Three events set the reset-cause bit: a supply undervoltage, a reset-pin assertion, and a software-reset write. The interrupt output models an active-low open-drain pin as a pull-down enable. It stays released during the startup window and pulls low as soon as STANDBY is reached, because the reset-cause bit is set. The host therefore learns from one falling edge that the registers hold their defaults and can be written.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Directly after the synchronous reset, `state_o` is 0 (OFF), `int_oe_o` is 0, `bus_ready_o` is 0 and `rd_data_o` is 0.
- R2: While the synchronised reset pin is low or the synchronised undervoltage flag is high, `state_o` stays 0 (OFF), writes have no effect, `rd_data_o` reads 0 and `int_oe_o` is 0.
- R3: Once the device is released, `state_o` is 1 (BOOT) for exactly `CLK_KHZ*WAIT_US/1000` cycles, 12 with the bench parameters. During BOOT, writes are ignored, reads return 0 and `bus_ready_o` is 0.
- R4: After BOOT, `state_o` becomes 2 (STANDBY) and `bus_ready_o` becomes 1. The registers then read their defaults: address 1 (status) reads 0x01, address 2 (mask) reads 0x00 and address 3 (config) reads `CFG_DEFAULT` (0xA5).
- R5: `int_oe_o` is 0 in OFF and BOOT and becomes 1 in the first STANDBY cycle, because status bit 0 (reset cause) is set.
- R6: A write to address 1 with data bit 0 set clears status bit 0. A write to address 1 with bit 0 clear changes nothing.
- R7: In STANDBY, `int_oe_o` equals status bit 0 AND NOT mask bit 0. Mask bit 0 is written at address 2, and only bit 0 of the mask and of the status is stored.
- R8: A write to address 0 with bit 0 set reloads all registers to their defaults on that clock edge, which sets the reset cause again. The device stays in STANDBY with no new startup window. Address 0 always reads 0.
- R9: An undervoltage or a low reset pin during STANDBY returns the device to OFF. Recovery runs a new startup window and ends in STANDBY with the registers at their defaults and `int_oe_o` at 1.
- R10: A change on the reset pin or the undervoltage flag reaches `state_o` on the third rising clock edge after it is applied, through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_i | input | 1 | External reset-release pin, asynchronous, high allows operation |
| uv_i | input | 1 | Analog supply undervoltage flag, asynchronous, high holds off |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 status, 2 mask, 3 config |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | 8 | Read data, 0 unless in STANDBY |
| bus_ready_o | output | 1 | Register port accepts accesses (STANDBY) |
| int_oe_o | output | 1 | Pull-down enable of the active-low open-drain interrupt pin |
| state_o | output | 2 | Sequencer state: 0 OFF, 1 BOOT, 2 STANDBY |

## Verification
The hardest case to reach from the ports is a write to the status or configuration register during the startup window. The port is closed there, so the only evidence that the write was dropped comes later, when the defaults are read back and the interrupt pulls low on entry to STANDBY. The bench issues a config write and a status-clear write inside the BOOT window and counts the window cycle by cycle. It then checks that both the default config value and the asserted interrupt survive. A similar check covers recovery from undervoltage: the config register is changed and the status bit is cleared first, so that the reload and the return of the interrupt can be seen.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_BOOT    = 2'd1,
        ST_STANDBY = 2'd2
    } seq_state_e;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd3;

    // clock cycles spanned by a wait given in microseconds
    function automatic int wait_cycles(input int clk_khz, input int wait_us);
        int c;
        c = (clk_khz * wait_us) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1_q, st2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1_q <= 1'b0;
                st2_q <= 1'b0;
            end else begin
                st1_q <= async_i[i];
                st2_q <= st1_q;
            end
        end
        assign sync_o[i] = st2_q;
    end
endmodule

// File: rtl/psc_seq.sv
module psc_seq
    import pwr_seq_pkg::*;
#(
    parameter int WAIT_CYC = 12,
    localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else if (hold) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_q <= ST_BOOT;
                    cnt_q   <= '0;
                end
                ST_BOOT: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_STANDBY;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_STANDBY;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/psc_regs.sv
module psc_regs
    import pwr_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG_DEFAULT = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_open,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_bit,
    output logic              mask_bit,
    output logic [DATA_W-1:0] cfg_q,
    output logic              int_req
);
    logic we, swrst;

    assign we    = wr_en & bus_open;
    assign swrst = we & (wr_addr == A_CTRL) & wr_data[0];

    // defaults load while closed and on a software reset
    always_ff @(posedge clk) begin
        if (rst || !bus_open || swrst) begin
            stat_bit <= 1'b1;
            mask_bit <= 1'b0;
            cfg_q    <= CFG_DEFAULT;
        end else if (we) begin
            unique case (wr_addr)
                A_STAT:  if (wr_data[0]) stat_bit <= 1'b0;
                A_MASK:  mask_bit <= wr_data[0];
                A_CFG:   cfg_q    <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (bus_open) begin
            unique case (rd_addr)
                A_STAT:  rd_data = {{(DATA_W-1){1'b0}}, stat_bit};
                A_MASK:  rd_data = {{(DATA_W-1){1'b0}}, mask_bit};
                A_CFG:   rd_data = cfg_q;
                default: rd_data = '0;
            endcase
        end
    end

    assign int_req = bus_open & stat_bit & ~mask_bit;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CLK_KHZ = 125000,
    parameter int WAIT_US = 1200,
    parameter logic [7:0] CFG_DEFAULT = 8'hA5,
    localparam int WAIT_CYC = wait_cycles(CLK_KHZ, WAIT_US),
    localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin_i,
    input  logic       uv_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [1:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       bus_ready_o,
    output logic       int_oe_o,
    output logic [1:0] state_o
);
    logic [1:0]       pins_s;
    logic             hold;
    seq_state_e       state;
    logic [CNT_W-1:0] boot_cnt;
    logic             stat_bit, mask_bit, int_req;
    logic [7:0]       cfg_q;

    psc_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({uv_i, rst_pin_i}),
        .sync_o  (pins_s)
    );

    assign hold = ~pins_s[0] | pins_s[1];

    psc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .state_o (state),
        .cnt_o   (boot_cnt)
    );

    assign bus_ready_o = (state == ST_STANDBY);

    psc_regs #(.CFG_DEFAULT(CFG_DEFAULT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_open (bus_ready_o),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .stat_bit (stat_bit),
        .mask_bit (mask_bit),
        .cfg_q    (cfg_q),
        .int_req  (int_req)
    );

    assign int_oe_o = int_req;
    assign state_o  = state;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
#(
    parameter int WAIT_CYC = 12,
    parameter logic [7:0] CFG_DEFAULT = 8'hA5,
    localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             hold,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] boot_cnt,
    input logic             int_oe_o,
    input logic             bus_ready_o,
    input logic [7:0]       rd_data_o,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [7:0]       wr_data_i,
    input logic             stat_bit,
    input logic             mask_bit,
    input logic [7:0]       cfg_q
);
    AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_o != ST_STANDBY) |-> (!int_oe_o && !bus_ready_o && rd_data_o == 8'h00)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_BOOT) |-> (boot_cnt < CNT_W'(WAIT_CYC))); // R3

    AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_BOOT && boot_cnt == CNT_W'(WAIT_CYC - 1) && !hold)
        |=> (state_o == ST_STANDBY)); // R3

    AST_STBY_FROM_BOOT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_STANDBY && $past(state_o) != ST_STANDBY)
        |-> ($past(state_o) == ST_BOOT)); // R4

    AST_INT_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_STANDBY && $past(state_o) == ST_BOOT) |-> int_oe_o); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && bus_ready_o && wr_addr_i == A_STAT && wr_data_i[0])
        |=> !stat_bit); // R6

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mask_bit |-> !int_oe_o); // R7

    AST_SWRST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && bus_ready_o && wr_addr_i == A_CTRL && wr_data_i[0] && !hold)
        |=> (state_o == ST_STANDBY && stat_bit && !mask_bit && cfg_q == CFG_DEFAULT)); // R8

    AST_HOLD_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        hold |=> (state_o == ST_OFF)); // R9
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
    .WAIT_CYC    (WAIT_CYC),
    .CFG_DEFAULT (CFG_DEFAULT)
) u_chk (.*);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    localparam int CLK_KHZ = 10;
    localparam int WAIT_US = 1200;
    localparam int WAIT_CYC = CLK_KHZ * WAIT_US / 1000;
    localparam logic [7:0] CFG_DEF = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin = 1'b0;
    logic       uv = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       bus_ready, int_oe;
    logic [1:0] state;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(
        .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .CFG_DEFAULT(CFG_DEF)
    ) u_dut (
        .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .uv_i(uv),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .bus_ready_o(bus_ready), .int_oe_o(int_oe), .state_o(state)
    );

    // vector: {we, waddr[1:0], wdata[7:0], raddr[1:0], exp_rd[7:0], exp_int}
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'h00, 2'd1, 8'h01, 1'b1},  // R6 write 0: status kept
        {1'b1, 2'd2, 8'hFF, 2'd2, 8'h01, 1'b0},  // R7 mask set, only bit0 kept
        {1'b1, 2'd2, 8'h00, 2'd1, 8'h01, 1'b1},  // R7 unmask
        {1'b1, 2'd1, 8'h01, 2'd1, 8'h00, 1'b0},  // R6 W1C clears
        {1'b1, 2'd3, 8'h3C, 2'd3, 8'h3C, 1'b0},  // config write
        {1'b1, 2'd2, 8'h01, 2'd2, 8'h01, 1'b0},  // R7 mask with nothing pending
        {1'b1, 2'd0, 8'h01, 2'd3, CFG_DEF, 1'b1},// R8 soft reset reloads config
        {1'b0, 2'd0, 8'h00, 2'd2, 8'h00, 1'b1},  // R8 mask back to default
        {1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b1},  // R8 control reads 0
        {1'b1, 2'd1, 8'h01, 2'd1, 8'h00, 1'b0}   // R6 clear again
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s);
        for (int i = 0; i < 200 && state != s; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", state, 2'd0);
        chk("R1 int", int_oe, 1'b0);
        chk("R1 ready", bus_ready, 1'b0);
        chk("R1 rd", rd_data, 8'h00);

        // R2 writes while held off, reads 0
        rd_addr = 2'd3;
        wr(2'd3, 8'h11);
        chk("R2 rd while off", rd_data, 8'h00);
        chk("R2 int while off", int_oe, 1'b0);

        // R10 synchroniser latency
        rst_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 still off after two edges", state, 2'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 boot on third edge", state, 2'd1);

        // R3 window length, writes inside window ignored
        n = 1;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h11;
        @(posedge clk); @(negedge clk);
        if (state == 2'd1) n++;
        wr_addr = 2'd1; wr_data = 8'h01;
        chk("R3 ready low in boot", bus_ready, 1'b0);
        chk("R5 int low in boot", int_oe, 1'b0);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (state == 2'd1) n++;
        for (int i = 0; i < 100 && state == 2'd1; i++) begin
            @(posedge clk); @(negedge clk);
            if (state == 2'd1) n++;
        end
        chk("R3 boot cycles", n, WAIT_CYC);

        // R4 / R5 standby defaults
        chk("R4 state standby", state, 2'd2);
        chk("R4 ready", bus_ready, 1'b1);
        chk("R5 int on entry", int_oe, 1'b1);
        rd_addr = 2'd1; #1 chk("R4 status default", rd_data, 8'h01);
        rd_addr = 2'd2; #1 chk("R4 mask default", rd_data, 8'h00);
        rd_addr = 2'd3; #1 chk("R4/R3 config default, boot write dropped", rd_data, CFG_DEF);

        // table walk: R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            wr_en   = VEC[v][21];
            wr_addr = VEC[v][20:19];
            wr_data = VEC[v][18:11];
            rd_addr = VEC[v][10:9];
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            chk($sformatf("R6/R7/R8 row %0d rd", v), rd_data, VEC[v][8:1]);
            chk($sformatf("R6/R7/R8 row %0d int", v), int_oe, VEC[v][0]);
            chk($sformatf("R8 row %0d stays standby", v), state, 2'd2);
        end

        // R9 undervoltage recovery
        wr(2'd3, 8'h77);
        uv = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 uv -> off", state, 2'd0);
        chk("R9 int released", int_oe, 1'b0);
        uv = 1'b0;
        wait_state(2'd2);
        chk("R9 back to standby", state, 2'd2);
        chk("R9 int after uv", int_oe, 1'b1);
        rd_addr = 2'd3; #1 chk("R9 config reloaded", rd_data, CFG_DEF);

        // R9 reset pin assertion as cause
        wr(2'd1, 8'h01);
        chk("R6 cleared before pin reset", int_oe, 1'b0);
        rst_pin = 1'b0;
        wait_state(2'd0);
        chk("R9 pin low -> off", state, 2'd0);
        rd_addr = 2'd1; #1 chk("R2 rd off", rd_data, 8'h00);
        rst_pin = 1'b1;
        wait_state(2'd2);
        chk("R9 int after pin reset", int_oe, 1'b1);
        rd_addr = 2'd1; #1 chk("R9 status set", rd_data, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule